// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Masked-Write Alias

This block is a register-mapped GPIO bank built from one or more controllers. Each controller serves four ports of eight pads, so pad `n` sits in port `n >> 3`, bit `n & 7`, and in controller `n >> 5`. Every port carries eight 8-bit registers: pad ownership, direction, output level, synchronized input, interrupt status, interrupt enable, interrupt polarity and interrupt acknowledge. Each register appears at a computed address. A second copy of each register, 0x80 above it, accepts masked writes. Software can then change single bits without a read-modify-write sequence.

A pad is driven either by the bank's own registers or by a special-function path that enters on `sf_out`/`sf_oe`. The pad's ownership bit selects between the two. Input levels pass through a two-flop synchronizer. An edge of the selected polarity on a pad with its interrupt enabled sets a sticky status bit. One combined `irq` line reports any enabled status bit that is set.

The register bus is a single write strobe with a combinational read port. A register written on one clock edge reads back its new value in the following cycle.

Top module: `gpio_bank`

## Requirements
- R1: The byte address of a register is controller×0x100 + kind×0x10 + port×4. The kind codes are 0 ownership, 1 direction, 2 output, 3 input, 4 status, 5 enable, 6 polarity and 7 acknowledge. Reads are combinational on `bus_rdata`, and a write is visible on a read in the next cycle. Reading through the alias (+0x80) returns the same value as the plain address.
- R2: A plain write to an ownership, direction, output, enable or polarity register replaces all eight bits with `bus_wdata[7:0]`.
- R3: A write to address+0x80 changes only the bits whose mask bit in `bus_wdata[15:8]` is 1. Those bits take `bus_wdata[7:0]`, and every other bit keeps its value.
- R4: The bank numbers pads as global port×8 + bit. When a pad's ownership bit is 1, `pad_oe` is its direction bit and `pad_out` is its output bit. When the ownership bit is 0, the pad follows `sf_oe`/`sf_out`.
- R5: The input register shows the pad level two clock edges after it changes, and not after one. This holds whatever the pad's direction.
- R6: With its enable bit 1, a status bit is set by a rising synchronized edge when its polarity bit is 1, or by a falling edge when its polarity bit is 0. A pad whose enable bit is 0 never sets its status bit.
- R7: Writing the acknowledge register clears each status bit whose data bit is 1. Through the alias, it clears bits where both the mask and the value are 1. The acknowledge register reads as zero.
- R8: `irq` is high exactly when some status bit is set and its enable bit is 1. It drops when enable bits are cleared, even if status remains.
- R9: Writes to the input and status registers have no effect. Writes to unmapped addresses also have no effect, where unmapped means a controller index ≥ NUM_CTRL or `bus_addr[1:0]` ≠ 0. Reads of unmapped addresses return zero.
- R10: After reset every register is zero, all pads follow the special-function path, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8+CW | Byte address, CW = max(1, clog2(NUM_CTRL)) |
| bus_wdata | input | 16 | Write data; [15:8] mask and [7:0] value for alias writes |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 32×NUM_CTRL | Pad levels from the pins |
| pad_out | output | 32×NUM_CTRL | Level driven onto each pad |
| pad_oe | output | 32×NUM_CTRL | Drive enable for each pad |
| sf_out | input | 32×NUM_CTRL | Special-function output levels |
| sf_oe | input | 32×NUM_CTRL | Special-function drive enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the bank with NUM_CTRL = 3. The controller field is then two bits wide, and controller index 3 is encodable but unmapped, so the out-of-range decode path in R9 can be reached. Twelve ports give random plain and masked writes room to land on every register kind across three controllers. The checks cover readback and the resulting pad drive. Directed sequences on one port cover synchronizer latency, both edge polarities, plain and masked acknowledge, and `irq` masking.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NUM_CTRL = 2,
  localparam int CW = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
  localparam int ADDR_W = 8 + CW,
  localparam int NPADS = NUM_CTRL * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPADS-1:0]  pad_in,
  output logic [NPADS-1:0]  pad_out,
  output logic [NPADS-1:0]  pad_oe,
  input  logic [NPADS-1:0]  sf_out,
  input  logic [NPADS-1:0]  sf_oe,
  output logic              irq
);
  localparam int NPORTS = NUM_CTRL * 4;
  localparam int PIW = CW + 2;

  typedef enum logic [2:0] {
    K_OWN = 3'd0, K_DIR = 3'd1, K_OUT = 3'd2, K_IN = 3'd3,
    K_STA = 3'd4, K_ENB = 3'd5, K_POL = 3'd6, K_ACK = 3'd7
  } kind_t;

  logic [NPORTS-1:0][7:0] own_q, dir_q, out_q, sta_q, enb_q, pol_q;
  logic [NPORTS-1:0][7:0] set_v, clr_v;
  logic [NPORTS-1:0]      hit;
  logic [NPADS-1:0]       sync1, sync2, sync3;
  logic [1:0]             warm;

  // address decode
  logic [CW-1:0]  a_ctrl;
  logic [PIW-1:0] a_port;
  logic           a_alias, a_ok;
  kind_t          a_kind;
  logic [7:0]     wmask, wval;

  assign a_ctrl  = bus_addr[ADDR_W-1:8];
  assign a_alias = bus_addr[7];
  assign a_kind  = kind_t'(bus_addr[6:4]);
  assign a_port  = {a_ctrl, bus_addr[3:2]};
  assign a_ok    = (bus_addr[1:0] == 2'b00) && (int'(a_ctrl) < NUM_CTRL);
  assign wmask   = bus_wdata[15:8];
  assign wval    = bus_wdata[7:0];

  function automatic logic [7:0] merged(input logic [7:0] old, input logic alias_sel,
                                        input logic [7:0] m, input logic [7:0] v);
    return alias_sel ? ((old & ~m) | (v & m)) : v;
  endfunction

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      hit[p] = bus_wr && a_ok && (a_port == PIW'(p));
      set_v[p] = enb_q[p] &
                 (( pol_q[p] &  sync2[p*8 +: 8] & ~sync3[p*8 +: 8]) |
                  (~pol_q[p] & ~sync2[p*8 +: 8] &  sync3[p*8 +: 8]));
      clr_v[p] = (hit[p] && a_kind == K_ACK) ? (a_alias ? (wmask & wval) : wval) : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= '0; dir_q <= '0; out_q <= '0;
      sta_q <= '0; enb_q <= '0; pol_q <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        if (hit[p] && a_kind == K_OWN) own_q[p] <= merged(own_q[p], a_alias, wmask, wval);
        if (hit[p] && a_kind == K_DIR) dir_q[p] <= merged(dir_q[p], a_alias, wmask, wval);
        if (hit[p] && a_kind == K_OUT) out_q[p] <= merged(out_q[p], a_alias, wmask, wval);
        if (hit[p] && a_kind == K_ENB) enb_q[p] <= merged(enb_q[p], a_alias, wmask, wval);
        if (hit[p] && a_kind == K_POL) pol_q[p] <= merged(pol_q[p], a_alias, wmask, wval);
        sta_q[p] <= (sta_q[p] & ~clr_v[p]) | set_v[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; sync3 <= '0; warm <= 2'd0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      sync3 <= sync2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // pad drive
  assign pad_oe  = (own_q & dir_q) | (~own_q & sf_oe);
  assign pad_out = (own_q & out_q) | (~own_q & sf_out);
  assign irq     = |(sta_q & enb_q);

  // read port
  logic [7:0] rd_sel;
  always_comb begin
    case (a_kind)
      K_OWN:   rd_sel = own_q[a_port];
      K_DIR:   rd_sel = dir_q[a_port];
      K_OUT:   rd_sel = out_q[a_port];
      K_IN:    rd_sel = sync2[a_port*8 +: 8];
      K_STA:   rd_sel = sta_q[a_port];
      K_ENB:   rd_sel = enb_q[a_port];
      K_POL:   rd_sel = pol_q[a_port];
      default: rd_sel = 8'h00;
    endcase
  end
  assign bus_rdata = a_ok ? rd_sel : 8'h00;

  assert_sync_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (sync2 == $past(pad_in, 2)));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[p] && !a_alias && a_kind == K_DIR) |=> (dir_q[p] == $past(wval)));
    assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[p] && a_alias && a_kind == K_OUT) |=>
        ((out_q[p] & ~$past(wmask)) == ($past(out_q[p]) & ~$past(wmask))));
    assert_no_set_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sta_q[p] & ~$past(sta_q[p]) & ~$past(enb_q[p])) == 8'h00));
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_v[p]) |=> ((sta_q[p] & $past(clr_v[p]) & ~$past(set_v[p])) == 8'h00));
  end
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int NC = 3;
  localparam int NP = NC * 4;
  localparam int NPADS = NC * 32;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NPADS-1:0] pad_in = '0, pad_out, pad_oe, sf_out, sf_oe;
  logic irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  gpio_bank #(.NUM_CTRL(NC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .sf_out(sf_out), .sf_oe(sf_oe), .irq(irq));

  always #2 clk = ~clk;

  logic [7:0] m_own[NP], m_dir[NP], m_out[NP], m_enb[NP], m_pol[NP];

  function automatic logic [AW-1:0] addr_of(int gp, int kind, bit al);
    return AW'((gp / 4) * 256 + (al ? 128 : 0) + kind * 16 + (gp % 4) * 4);
  endfunction

  function automatic logic [NPADS-1:0] exp_pads(bit want_oe);
    logic [NPADS-1:0] v;
    for (int g = 0; g < NP; g++)
      for (int b = 0; b < 8; b++)
        v[g*8+b] = m_own[g][b] ? (want_oe ? m_dir[g][b] : m_out[g][b])
                               : (want_oe ? sf_oe[g*8+b] : sf_out[g*8+b]);
    return v;
  endfunction

  function automatic logic [7:0] apply(logic [7:0] old, bit al, logic [15:0] d);
    return al ? ((old & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'd4242);
    sf_out = {$urandom, $urandom, $urandom};
    sf_oe  = {$urandom, $urandom, $urandom};
    for (int g = 0; g < NP; g++) begin
      m_own[g] = 0; m_dir[g] = 0; m_out[g] = 0; m_enb[g] = 0; m_pol[g] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(addr_of(0, 0, 0), v); chk("R10 own reset", v, 0);
    rd(addr_of(11, 5, 0), v); chk("R10 enb reset", v, 0);
    chk("R10 pad_oe follows sf", pad_oe, sf_oe);
    chk("R10 pad_out follows sf", pad_out, sf_out);
    chk("R10 irq low", irq, 0);

    // R1 R2 R3 R4 random plain and masked writes
    for (int i = 0; i < 300; i++) begin
      int gp, kind;
      bit al;
      logic [15:0] d;
      logic [7:0] e;
      gp = $urandom_range(0, NP - 1);
      kind = $urandom_range(0, 7);
      al = 1'($urandom_range(0, 1));
      d = 16'($urandom);
      wr(addr_of(gp, kind, al), d);
      case (kind)
        0: m_own[gp] = apply(m_own[gp], al, d);
        1: m_dir[gp] = apply(m_dir[gp], al, d);
        2: m_out[gp] = apply(m_out[gp], al, d);
        5: m_enb[gp] = apply(m_enb[gp], al, d);
        6: m_pol[gp] = apply(m_pol[gp], al, d);
        default: ;
      endcase
      case (kind)
        0: e = m_own[gp];
        1: e = m_dir[gp];
        2: e = m_out[gp];
        5: e = m_enb[gp];
        6: e = m_pol[gp];
        default: e = 8'h00;
      endcase
      rd(addr_of(gp, kind, 0), v);
      chk(al ? "R3 masked write readback" : "R2 plain write readback", v, e);
      rd(addr_of(gp, kind, 1), v);
      chk("R1 alias read matches", v, e);
      chk("R4 pad_oe", pad_oe, exp_pads(1));
      chk("R4 pad_out", pad_out, exp_pads(0));
    end

    // interrupt and sync on port 5
    wr(addr_of(5, 0, 0), 16'h00FF); m_own[5] = 8'hFF;
    wr(addr_of(5, 1, 0), 16'h00FF); m_dir[5] = 8'hFF;
    for (int g = 0; g < NP; g++) begin
      wr(addr_of(g, 5, 0), 16'h0000); m_enb[g] = 0;
    end
    wr(addr_of(5, 5, 0), 16'h000F); m_enb[5] = 8'h0F;
    wr(addr_of(5, 6, 0), 16'h0005); m_pol[5] = 8'h05;
    chk("R8 irq idle", irq, 0);

    pad_in[47:40] = 8'hFF;
    @(negedge clk);
    rd(addr_of(5, 3, 0), v); chk("R5 one edge not yet", v, 8'h00);
    @(negedge clk);
    rd(addr_of(5, 3, 0), v); chk("R5 two edges output pad", v, 8'hFF);
    @(negedge clk);
    rd(addr_of(5, 4, 0), v); chk("R6 rising polarity", v, 8'h05);
    chk("R8 irq set", irq, 1);

    pad_in[47:40] = 8'h00;
    repeat (3) @(negedge clk);
    rd(addr_of(5, 4, 0), v); chk("R6 falling polarity", v, 8'h0F);

    wr(addr_of(5, 7, 0), 16'h0001);
    rd(addr_of(5, 4, 0), v); chk("R7 plain ack", v, 8'h0E);
    rd(addr_of(5, 7, 0), v); chk("R7 ack reads zero", v, 8'h00);
    wr(addr_of(5, 7, 1), 16'h0602);
    rd(addr_of(5, 4, 0), v); chk("R7 masked ack", v, 8'h0C);
    chk("R8 irq still set", irq, 1);
    wr(addr_of(5, 5, 1), 16'h0C00); m_enb[5] = 8'h03;
    chk("R8 irq masked by enable", irq, 0);
    rd(addr_of(5, 4, 0), v); chk("R8 status kept", v, 8'h0C);

    pad_in[44] = 1'b1;
    repeat (3) @(negedge clk);
    rd(addr_of(5, 4, 0), v); chk("R6 disabled pad no set", v, 8'h0C);
    chk("R6 irq stays low", irq, 0);

    // R9 ignored writes and unmapped space
    wr(addr_of(5, 3, 0), 16'h00AA);
    rd(addr_of(5, 3, 0), v); chk("R9 input write ignored", v, 8'h10);
    wr(addr_of(5, 4, 0), 16'h00FF);
    rd(addr_of(5, 4, 0), v); chk("R9 status write ignored", v, 8'h0C);
    wr(AW'(10'h320), 16'h00FF);
    rd(AW'(10'h320), v); chk("R9 unmapped controller reads zero", v, 8'h00);
    wr(addr_of(0, 2, 0) + AW'(1), 16'h00AA);
    rd(addr_of(0, 2, 0), v); chk("R9 misaligned write ignored", v, m_out[0]);
    rd(addr_of(0, 2, 0) + AW'(1), v); chk("R9 misaligned read zero", v, 8'h00);
    chk("R9 pads unchanged", pad_out, exp_pads(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule